// File: doc/BRIEF.md
# Windowed 64-bit Register Access Bridge

This block gives a host that only has a 32-bit register port a way to reach a bank of 64-bit registers that live behind an internal bus. The host sees a small window of 32-bit locations. To write a wide register it stages the upper half and the lower half in two data words and then writes a command word. The command word carries the target register address and a direction bit. To read, it writes a command word with the direction bit clear and, once the bridge is idle again, collects the two halves of the result from the same data words.

The bridge runs one internal access at a time. It holds its request on the internal bus until the target acknowledges or a fixed cycle budget runs out. It reports progress and faults in a status word. A fault flag stays set until the host writes the reset location. That write also abandons any access still in flight.

Top module: `regwin_bridge`

## Requirements
- R1: Window offset 0x00 holds the upper 32 bits (63:32) of the staged 64-bit value and offset 0x04 holds the lower 32 bits (31:0); a host write to either one is returned by a later host read of the same offset.
- R2: A host write to offset 0x08 with bit 31 set, while the bridge is idle, starts an internal write: ib_req rises on the next cycle with ib_we=1, ib_addr equal to command bits IB_AW-1:0 and ib_wdata equal to {word 0x00, word 0x04}; ib_req stays high until ib_ack is sampled.
- R3: A command write with bit 31 clear starts an internal read; when ib_ack is sampled, ib_rdata bits 63:32 land in word 0x00 and bits 31:0 in word 0x04.
- R4: Status (offset 0x1C) bit 0 reads 1 from the cycle after an accepted command write until the access ends, and 0 otherwise.
- R5: A command write while bit 0 of status is set is ignored (the access in flight keeps its address and direction, and nothing else is started) and sets status bit 31.
- R6: If no acknowledge is sampled in TIMEOUT consecutive request cycles, the bridge drops ib_req, sets status bit 31, and for a read writes zero into both data words; an acknowledge in the TIMEOUT-th cycle still counts as success.
- R7: Status bit 31 is sticky: later accesses that succeed leave it set, and only a write of any value to offset 0x18, or the block reset, clears it.
- R8: A write to offset 0x18 abandons the access in flight: ib_req is low and status reads 0 from the next cycle on, and a read that was abandoned does not change the data words.
- R9: Host reads return data one cycle after host_rd; offset 0x08 returns the last accepted command, and offsets 0x18 and 0x20 and unmapped offsets return zero.
- R10: After reset, ib_req is low and the status word and both data words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | HOST_AW | Byte offset inside the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data, valid the cycle after host_rd |
| ib_req | output | 1 | Internal access request, held until acknowledged or timed out |
| ib_we | output | 1 | Internal access direction, 1 for write |
| ib_addr | output | IB_AW | Internal register address |
| ib_wdata | output | 64 | Internal write data |
| ib_ack | input | 1 | Internal access acknowledge |
| ib_rdata | input | 64 | Internal read data, valid with ib_ack |

## Verification
The bench builds the bridge with IB_AW=4 and TIMEOUT=8. This makes the whole internal register space of 16 entries small enough to write and read back one by one. It also makes the acknowledge delay short enough to sweep across the timeout edge. Every acknowledge delay from zero up to one past the budget is driven, so both the last cycle that still succeeds and the first one that times out are hit. The short budget also puts the busy window, a command rejected while busy and an abort through the reset location within a few cycles of each other.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam logic [7:0] OFS_HI   = 8'h00;
  localparam logic [7:0] OFS_LO   = 8'h04;
  localparam logic [7:0] OFS_CMD  = 8'h08;
  localparam logic [7:0] OFS_CLR  = 8'h18;
  localparam logic [7:0] OFS_STS  = 8'h1C;
  localparam logic [7:0] OFS_IRQ  = 8'h20;

  localparam int CMD_DIR_BIT = 31;
  localparam int STS_ERR_BIT = 31;
  localparam int STS_BSY_BIT = 0;

  typedef struct packed {
    logic hi;
    logic lo;
    logic cmd;
    logic clr;
    logic sts;
    logic irq;
  } regwin_sel_t;

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int HOST_AW = 6
) (
  input  logic [HOST_AW-1:0] addr,
  output regwin_sel_t        sel
);

  logic [7:0] a8;

  always_comb begin
    a8      = 8'(addr);
    sel.hi  = (a8 == OFS_HI);
    sel.lo  = (a8 == OFS_LO);
    sel.cmd = (a8 == OFS_CMD);
    sel.clr = (a8 == OFS_CLR);
    sel.sts = (a8 == OFS_STS);
    sel.irq = (a8 == OFS_IRQ);
  end

endmodule

// File: rtl/regwin_engine.sv
module regwin_engine #(
  parameter int IB_AW   = 16,
  parameter int TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             launch_we,
  input  logic [IB_AW-1:0] launch_addr,
  input  logic [63:0]      launch_data,
  input  logic             abort,
  output logic             busy,
  output logic             done,
  output logic             done_err,
  output logic             done_rd,
  output logic             ib_req,
  output logic             ib_we,
  output logic [IB_AW-1:0] ib_addr,
  output logic [63:0]      ib_wdata,
  input  logic             ib_ack
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] wait_cnt;
  logic          expired;

  assign busy     = ib_req;
  assign expired  = (wait_cnt == LAST);
  assign done     = ib_req && !abort && (ib_ack || expired);
  assign done_err = !ib_ack;
  assign done_rd  = !ib_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      ib_req   <= 1'b0;
      ib_we    <= 1'b0;
      ib_addr  <= '0;
      ib_wdata <= '0;
      wait_cnt <= '0;
    end else if (abort) begin
      ib_req   <= 1'b0;
      wait_cnt <= '0;
    end else if (launch && !ib_req) begin
      ib_req   <= 1'b1;
      ib_we    <= launch_we;
      ib_addr  <= launch_addr;
      ib_wdata <= launch_data;
      wait_cnt <= '0;
    end else if (done) begin
      ib_req   <= 1'b0;
      wait_cnt <= '0;
    end else if (ib_req) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int HOST_AW = 6,
  parameter int IB_AW   = 16,
  parameter int TIMEOUT = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               ib_req,
  output logic               ib_we,
  output logic [IB_AW-1:0]   ib_addr,
  output logic [63:0]        ib_wdata,
  input  logic               ib_ack,
  input  logic [63:0]        ib_rdata
);

  regwin_sel_t sel;
  logic [31:0] word_hi, word_lo, cmd_q;
  logic        err_q, busy, done, done_err, done_rd;
  logic        wr_cmd, wr_clr, launch, reject;

  regwin_decode #(.HOST_AW(HOST_AW)) u_dec (
    .addr (host_addr),
    .sel  (sel)
  );

  assign wr_cmd = host_wr && sel.cmd;
  assign wr_clr = host_wr && sel.clr;
  assign launch = wr_cmd && !busy;
  assign reject = wr_cmd && busy;

  regwin_engine #(.IB_AW(IB_AW), .TIMEOUT(TIMEOUT)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .launch_we   (host_wdata[CMD_DIR_BIT]),
    .launch_addr (host_wdata[IB_AW-1:0]),
    .launch_data ({word_hi, word_lo}),
    .abort       (wr_clr),
    .busy        (busy),
    .done        (done),
    .done_err    (done_err),
    .done_rd     (done_rd),
    .ib_req      (ib_req),
    .ib_we       (ib_we),
    .ib_addr     (ib_addr),
    .ib_wdata    (ib_wdata),
    .ib_ack      (ib_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_hi <= '0;
      word_lo <= '0;
      cmd_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (done && done_rd) begin
        word_hi <= done_err ? 32'h0 : ib_rdata[63:32];
        word_lo <= done_err ? 32'h0 : ib_rdata[31:0];
      end else begin
        if (host_wr && sel.hi) word_hi <= host_wdata;
        if (host_wr && sel.lo) word_lo <= host_wdata;
      end
      if (launch) cmd_q <= host_wdata;
      if (wr_clr) err_q <= 1'b0;
      else if (reject || (done && done_err)) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      unique case (1'b1)
        sel.hi:  host_rdata <= word_hi;
        sel.lo:  host_rdata <= word_lo;
        sel.cmd: host_rdata <= cmd_q;
        sel.sts: begin
          host_rdata              <= '0;
          host_rdata[STS_ERR_BIT] <= err_q;
          host_rdata[STS_BSY_BIT] <= busy;
        end
        default: host_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk
  import regwin_pkg::*;
#(
  parameter int HOST_AW = 6,
  parameter int IB_AW   = 16,
  parameter int TIMEOUT = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr,
  input logic [HOST_AW-1:0] host_addr,
  input logic               ib_req,
  input logic               ib_we,
  input logic [IB_AW-1:0]   ib_addr,
  input logic [63:0]        ib_wdata,
  input logic               ib_ack,
  input logic               err_q
);

  localparam int CW = $clog2(TIMEOUT + 2);

  logic [CW-1:0] req_run;
  logic          clr_wr, cmd_wr;

  assign clr_wr = host_wr && (8'(host_addr) == OFS_CLR);
  assign cmd_wr = host_wr && (8'(host_addr) == OFS_CMD);

  always_ff @(posedge clk) begin
    if (rst || !ib_req) req_run <= '0;
    else                req_run <= req_run + 1'b1;
  end

  // R2: request fields hold while waiting
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    ib_req && !ib_ack && !clr_wr |=> !ib_req ||
      ($stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)));

  // R3: an acknowledged request ends
  a_r3_ack_ends: assert property (@(posedge clk) disable iff (rst)
    ib_req && ib_ack |=> !ib_req);

  // R5: command while busy flags an error
  a_r5_busy_reject: assert property (@(posedge clk) disable iff (rst)
    ib_req && !ib_ack && cmd_wr |=> err_q);

  // R6: request never outlives the budget
  a_r6_budget: assert property (@(posedge clk) disable iff (rst)
    req_run <= CW'(TIMEOUT));

  // R6: expiry sets the error and drops the request
  a_r6_expire: assert property (@(posedge clk) disable iff (rst)
    ib_req && !ib_ack && !clr_wr && req_run == CW'(TIMEOUT - 1)
      |=> err_q && !ib_req);

  // R7: error stays until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q && !clr_wr |=> err_q);

  // R8: clear write aborts and clears
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> !ib_req && !err_q);

endmodule

bind regwin_bridge regwin_bridge_chk #(
  .HOST_AW (HOST_AW),
  .IB_AW   (IB_AW),
  .TIMEOUT (TIMEOUT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .ib_req    (ib_req),
  .ib_we     (ib_we),
  .ib_addr   (ib_addr),
  .ib_wdata  (ib_wdata),
  .ib_ack    (ib_ack),
  .err_q     (err_q)
);

// File: tb/regwin_bridge_tb.sv
module regwin_bridge_tb;

  localparam int HOST_AW = 6;
  localparam int IB_AW   = 4;
  localparam int TIMEOUT = 8;
  localparam int NREG    = 1 << IB_AW;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               host_wr = 1'b0, host_rd = 1'b0;
  logic [HOST_AW-1:0] host_addr = '0;
  logic [31:0]        host_wdata = '0;
  logic [31:0]        host_rdata;
  logic               ib_req, ib_we, ib_ack;
  logic [IB_AW-1:0]   ib_addr;
  logic [63:0]        ib_wdata, ib_rdata;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [63:0] smem [NREG];
  int          sl_delay = 0;
  int          sl_cnt = 0;

  always #4 clk = ~clk;

  regwin_bridge #(.HOST_AW(HOST_AW), .IB_AW(IB_AW), .TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
    .ib_ack(ib_ack), .ib_rdata(ib_rdata)
  );

  // internal register target model with programmable acknowledge delay
  initial begin
    ib_ack = 1'b0;
    ib_rdata = '0;
    for (int i = 0; i < NREG; i++) smem[i] = '0;
  end

  always @(negedge clk) begin
    if (!ib_req) begin
      ib_ack = 1'b0;
      sl_cnt = 0;
    end else if (ib_ack) begin
      ib_ack = 1'b0;
      sl_cnt = 0;
    end else if (sl_cnt == sl_delay) begin
      ib_ack = 1'b1;
      ib_rdata = smem[ib_addr];
      if (ib_we) smem[ib_addr] = ib_wdata;
    end else begin
      sl_cnt = sl_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = HOST_AW'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = HOST_AW'(a);
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 60; i++) begin
      hread(8'h1C, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  function automatic logic [63:0] pat(input int a, input int k);
    return {32'hC3A50000 ^ (32'(a) * 32'h01010101) ^ 32'(k),
            32'h0F1E2D3C + 32'(a) * 32'h11 + 32'(k) * 32'h100};
  endfunction

  initial begin
    logic [31:0] r;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    hread(8'h1C, r); chk("R10 status", r, 32'h0);
    hread(8'h00, r); chk("R10 word hi", r, 32'h0);
    hread(8'h04, r); chk("R10 word lo", r, 32'h0);
    chk("R10 ib_req", {31'b0, ib_req}, 32'h0);

    // R1: staging words read back
    hwrite(8'h00, 32'hDEADBEEF); hwrite(8'h04, 32'h01234567);
    hread(8'h00, r); chk("R1 word hi", r, 32'hDEADBEEF);
    hread(8'h04, r); chk("R1 word lo", r, 32'h01234567);

    // R2: write every internal register with delays 0..TIMEOUT-1
    for (int a = 0; a < NREG; a++) begin
      v = pat(a, 1);
      sl_delay = a % TIMEOUT;
      hwrite(8'h00, v[63:32]); hwrite(8'h04, v[31:0]);
      hwrite(8'h08, 32'h80000000 | 32'(a));
      wait_idle();
      chk($sformatf("R2 mem[%0d] hi", a), smem[a][63:32], v[63:32]);
      chk($sformatf("R2 mem[%0d] lo", a), smem[a][31:0], v[31:0]);
    end
    hread(8'h1C, r); chk("R6 no error within budget", r, 32'h0);

    // R3: read every register back with varied delays
    for (int a = 0; a < NREG; a++) begin
      v = pat(a, 1);
      sl_delay = (a * 3) % TIMEOUT;
      hwrite(8'h08, 32'(a));
      wait_idle();
      hread(8'h00, r); chk($sformatf("R3 rd[%0d] hi", a), r, v[63:32]);
      hread(8'h04, r); chk($sformatf("R3 rd[%0d] lo", a), r, v[31:0]);
    end
    // R9: command readback, zero locations
    hread(8'h08, r); chk("R9 cmd readback", r, 32'(NREG - 1));
    hread(8'h18, r); chk("R9 clear loc reads 0", r, 32'h0);
    hread(8'h20, r); chk("R9 irq loc reads 0", r, 32'h0);
    hread(8'h10, r); chk("R9 unmapped reads 0", r, 32'h0);

    // R4/R5: busy flag and rejected command
    sl_delay = 5;
    hwrite(8'h08, 32'd2);
    hread(8'h1C, r); chk("R4 busy set", r, 32'h1);
    hwrite(8'h08, 32'h80000007);
    wait_idle();
    chk("R5 rejected write no effect", smem[7][31:0], pat(7, 1));
    hread(8'h00, r); chk("R5 first access intact", r, pat(2, 1) >> 32);
    hread(8'h1C, r); chk("R5 error set", r, 32'h80000000);
    hread(8'h08, r); chk("R5 cmd not replaced", r, 32'd2);

    // R7: sticky across success, then cleared
    sl_delay = 0;
    hwrite(8'h08, 32'd4);
    wait_idle();
    hread(8'h1C, r); chk("R7 error sticky", r, 32'h80000000);
    hwrite(8'h18, 32'h12345678);
    hread(8'h1C, r); chk("R7 error cleared", r, 32'h0);

    // R6: boundary, ack in last cycle succeeds
    sl_delay = TIMEOUT - 1;
    hwrite(8'h08, 32'd5);
    wait_idle();
    hread(8'h1C, r); chk("R6 last-cycle ack ok", r, 32'h0);
    hread(8'h04, r); chk("R6 last-cycle data", r, pat(5, 1));

    // R6: one cycle late times out, read data zeroed
    sl_delay = TIMEOUT;
    hwrite(8'h08, 32'd6);
    wait_idle();
    hread(8'h1C, r); chk("R6 timeout error", r, 32'h80000000);
    hread(8'h00, r); chk("R6 timeout hi zero", r, 32'h0);
    hread(8'h04, r); chk("R6 timeout lo zero", r, 32'h0);
    hwrite(8'h18, 32'h0);

    // R6: timed-out write leaves target unchanged
    sl_delay = 100;
    hwrite(8'h00, 32'hAAAAAAAA); hwrite(8'h04, 32'h55555555);
    hwrite(8'h08, 32'h80000008);
    wait_idle();
    chk("R6 timed-out write dropped", smem[8][31:0], pat(8, 1));
    hread(8'h1C, r); chk("R6 write timeout error", r, 32'h80000000);
    hwrite(8'h18, 32'h0);

    // R8: abort an access in flight
    hwrite(8'h00, 32'h11112222); hwrite(8'h04, 32'h33334444);
    hwrite(8'h08, 32'd9);
    hwrite(8'h18, 32'hFFFFFFFF);
    chk("R8 ib_req dropped", {31'b0, ib_req}, 32'h0);
    hread(8'h1C, r); chk("R8 status idle", r, 32'h0);
    repeat (TIMEOUT + 2) @(negedge clk);
    hread(8'h00, r); chk("R8 aborted read no update", r, 32'h11112222);
    hread(8'h1C, r); chk("R8 no late error", r, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule